// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block gives an I/O controller a two-address configuration window on a byte-wide I/O bus. One address is the index port and the other is the data port. After reset the window is closed. It opens only when a fixed four-byte key is written to the index port. While the window is open, a write to the index port selects a configuration register, and the data port then reads or writes that register.

A logical device number register chooses which device bank the per-device registers reach. Each bank holds a 16-bit I/O base address and an activate bit. The activate bits leave the block as a vector, so the devices behind the window can be enabled. A chip identifier, a revision nibble and the device number register are visible whatever bank is selected. A fixed exit command written through the data port closes the window again.

Bus reads are combinational. A read strobe returns the addressed value in the same cycle. A write commits at the next rising clock edge.

Top module: `cfgport_top`

## Requirements
- R1: After synchronous reset the window is closed (`cfg_open` = 0), the device number is 0 and every bit of `dev_active` is 0.
- R2: `cfg_open` rises in the cycle after the fourth of the index-port writes 0x87, 0x01, 0x55, 0x55 made in that order. It does not rise after only the first three.
- R3: While closed, an index-port write that does not match the expected key byte restarts the match. If that byte is 0x87, it counts as the first key byte, so 0x87 0x87 0x01 0x55 0x55 opens the window and 0x87 0x01 0x55 0x56 does not.
- R4: While closed, data-port reads return 0xFF and data-port writes change no register and no `dev_active` bit.
- R5: While open, an index-port write selects the register number and an index-port read returns it. While closed, index-port reads return 0xFF.
- R6: Writing 0x02 to register 0x02 closes the window. Any other value written there leaves it open. Register 0x02 reads 0x00.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the chip identifier, and register 0x22 returns the revision in bits 3:0 with zeros above. These values read the same in every bank, and writes to them are ignored.
- R8: Register 0x07 holds the 8-bit logical device number, writable and readable. Later per-device accesses go to the bank it selects.
- R9: Register 0x30 holds the bank's activate bit in bit 0 and reads as {7'b0, bit}. That bit drives `dev_active[n]` for device n, and banks are independent.
- R10: Registers 0x60 and 0x61 hold the high and low bytes of the bank's 16-bit base address. Each bank keeps its own value.
- R11: When the device number is at or above NUM_DEV, per-device registers read 0x00 and writes to them are ignored.
- R12: When a read and a write hit the data port in the same cycle, `io_rdata` shows the value from before the write, and the new value is readable in the next cycle.
- R13: Accesses to any address other than the two ports return 0x00 and do not advance the key match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address of the current access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| cfg_open | output | 1 | Configuration window is unlocked |
| dev_active | output | NUM_DEV (12) | Activate bit of each device bank |

## Verification
Two functions can land in the same cycle: a combinational data-port read, and a data-port write that changes the very register being read. The bench raises both strobes together while it rewrites the device number. It expects the old number on `io_rdata` in that cycle and the new one in the following cycle. The same overlap occurs on the key path, where the final key byte and the opening of the window are one edge apart. The bench samples `cfg_open` after three key bytes and again after the fourth.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    // configuration register numbers
    localparam logic [7:0] RIX_EXIT  = 8'h02;
    localparam logic [7:0] RIX_LDN   = 8'h07;
    localparam logic [7:0] RIX_IDH   = 8'h20;
    localparam logic [7:0] RIX_IDL   = 8'h21;
    localparam logic [7:0] RIX_REV   = 8'h22;
    localparam logic [7:0] RIX_ACT   = 8'h30;
    localparam logic [7:0] RIX_BASEH = 8'h60;
    localparam logic [7:0] RIX_BASEL = 8'h61;

    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

    // one decoded bus access
    typedef struct packed {
        logic       idx_wr;
        logic       idx_rd;
        logic       dat_wr;
        logic       dat_rd;
        logic [7:0] data;
    } port_req_t;

    // position inside the unlock key
    typedef enum logic [1:0] {
        KEY_B0,
        KEY_B1,
        KEY_B2,
        KEY_B3
    } key_pos_e;

    function automatic logic [7:0] key_byte(key_pos_e p);
        case (p)
            KEY_B0:  return 8'h87;
            KEY_B1:  return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h002F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        wdata,
    output port_req_t         req
);

    logic hit_idx;
    logic hit_dat;

    assign hit_idx = (addr == IDX_ADDR);
    assign hit_dat = (addr == DAT_ADDR);

    always_comb begin
        req.idx_wr = hit_idx && wr;
        req.idx_rd = hit_idx && rd;
        req.dat_wr = hit_dat && wr;
        req.dat_rd = hit_dat && rd;
        req.data   = wdata;
    end

endmodule

// File: rtl/cfgport_keylock.sv
module cfgport_keylock
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_hit,
    output logic       open
);

    key_pos_e kpos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open   <= 1'b0;
            kpos_q <= KEY_B0;
        end else if (open) begin
            if (exit_hit) begin
                open   <= 1'b0;
                kpos_q <= KEY_B0;
            end
        end else if (idx_wr) begin
            if (wdata == key_byte(kpos_q)) begin
                if (kpos_q == KEY_B3) begin
                    open   <= 1'b1;
                    kpos_q <= KEY_B0;
                end else begin
                    kpos_q <= kpos_q.next();
                end
            end else if (wdata == key_byte(KEY_B0)) begin
                kpos_q <= KEY_B1;
            end else begin
                kpos_q <= KEY_B0;
            end
        end
    end

    // R2
    key_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open) |-> ($past(idx_wr) && $past(wdata) == 8'h55));

    // R6
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(open) |-> $past(exit_hit));

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int          NUM_DEV  = 12,
    parameter logic [15:0] CHIP_ID  = 16'h5A3C,
    parameter logic [3:0]  CHIP_REV = 4'h6
) (
    input  logic               clk,
    input  logic               rst,
    input  port_req_t          req,
    input  logic               open,
    output logic               exit_hit,
    output logic [7:0]         rdata,
    output logic [NUM_DEV-1:0] dev_active
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [7:0]         index_q;
    logic [7:0]         ldn_q;
    logic [NUM_DEV-1:0] act_q;
    logic [15:0]        base_q [NUM_DEV];

    logic             cfg_wr;
    logic             ldn_ok;
    logic [SEL_W-1:0] sel;

    assign cfg_wr   = open && req.dat_wr;
    assign ldn_ok   = (int'(ldn_q) < NUM_DEV);
    assign sel      = ldn_q[SEL_W-1:0];
    assign exit_hit = cfg_wr && (index_q == RIX_EXIT) && (req.data == EXIT_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (open && req.idx_wr)
                index_q <= req.data;
            if (cfg_wr && index_q == RIX_LDN)
                ldn_q <= req.data;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        logic bank_wr;
        assign bank_wr = cfg_wr && ldn_ok && (sel == SEL_W'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[d]  <= 1'b0;
                base_q[d] <= 16'h0000;
            end else if (bank_wr) begin
                if (index_q == RIX_ACT)
                    act_q[d] <= req.data[0];
                if (index_q == RIX_BASEH)
                    base_q[d][15:8] <= req.data;
                if (index_q == RIX_BASEL)
                    base_q[d][7:0] <= req.data;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (req.idx_rd || req.dat_rd) begin
            if (!open) begin
                rdata = LOCKED_READ;
            end else if (req.idx_rd) begin
                rdata = index_q;
            end else begin
                case (index_q)
                    RIX_LDN:   rdata = ldn_q;
                    RIX_IDH:   rdata = CHIP_ID[15:8];
                    RIX_IDL:   rdata = CHIP_ID[7:0];
                    RIX_REV:   rdata = {4'h0, CHIP_REV};
                    RIX_ACT:   rdata = ldn_ok ? {7'b0, act_q[sel]} : 8'h00;
                    RIX_BASEH: rdata = ldn_ok ? base_q[sel][15:8] : 8'h00;
                    RIX_BASEL: rdata = ldn_ok ? base_q[sel][7:0]  : 8'h00;
                    default:   rdata = 8'h00;
                endcase
            end
        end
    end

    assign dev_active = act_q;

    // R4
    locked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!open && req.dat_rd) |-> (rdata == LOCKED_READ));

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!open && req.dat_wr) |=> ($stable(dev_active) && $stable(ldn_q)));

    // R11
    bank_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !ldn_ok) |=> $stable(act_q));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h002F,
    parameter int                NUM_DEV  = 12,
    parameter logic [15:0]       CHIP_ID  = 16'h5A3C,
    parameter logic [3:0]        CHIP_REV = 4'h6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    output logic               cfg_open,
    output logic [NUM_DEV-1:0] dev_active
);

    port_req_t req;
    logic      exit_hit;

    cfgport_decode #(
        .ADDR_W  (ADDR_W),
        .IDX_ADDR(IDX_ADDR),
        .DAT_ADDR(DAT_ADDR)
    ) u_decode (
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .wdata(io_wdata),
        .req  (req)
    );

    cfgport_keylock u_keylock (
        .clk     (clk),
        .rst     (rst),
        .idx_wr  (req.idx_wr),
        .wdata   (req.data),
        .exit_hit(exit_hit),
        .open    (cfg_open)
    );

    cfgport_regs #(
        .NUM_DEV (NUM_DEV),
        .CHIP_ID (CHIP_ID),
        .CHIP_REV(CHIP_REV)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .open      (cfg_open),
        .exit_hit  (exit_hit),
        .rdata     (io_rdata),
        .dev_active(dev_active)
    );

endmodule

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    // entry: {kind[1:0], req[3:0], data[7:0], expected[7:0]}
    // kind 0 index write, 1 data write, 2 index read, 3 data read
    localparam int NVEC = 61;
    localparam logic [21:0] VEC [NVEC] = '{
        {2'd3, 4'd1,  8'h00, 8'hFF},  // R1 closed after reset
        {2'd2, 4'd5,  8'h00, 8'hFF},  // R5 index read while closed
        {2'd1, 4'd4,  8'h55, 8'h00},  // R4 data write ignored
        {2'd0, 4'd3,  8'h87, 8'h00},  // R3 bad key
        {2'd0, 4'd3,  8'h01, 8'h00},
        {2'd0, 4'd3,  8'h55, 8'h00},
        {2'd0, 4'd3,  8'h56, 8'h00},
        {2'd3, 4'd3,  8'h00, 8'hFF},  // R3 still closed
        {2'd0, 4'd3,  8'h87, 8'h00},  // R3 repeated first byte
        {2'd0, 4'd3,  8'h87, 8'h00},
        {2'd0, 4'd3,  8'h01, 8'h00},
        {2'd0, 4'd3,  8'h55, 8'h00},
        {2'd0, 4'd3,  8'h55, 8'h00},
        {2'd0, 4'd5,  8'h07, 8'h00},  // R5 select register
        {2'd2, 4'd5,  8'h00, 8'h07},
        {2'd3, 4'd1,  8'h00, 8'h00},  // R1 device number 0
        {2'd0, 4'd7,  8'h20, 8'h00},  // R7 identifier
        {2'd3, 4'd7,  8'h00, 8'h5A},
        {2'd0, 4'd7,  8'h21, 8'h00},
        {2'd3, 4'd7,  8'h00, 8'h3C},
        {2'd0, 4'd7,  8'h22, 8'h00},
        {2'd3, 4'd7,  8'h00, 8'h06},
        {2'd1, 4'd7,  8'hFF, 8'h00},
        {2'd3, 4'd7,  8'h00, 8'h06},
        {2'd0, 4'd8,  8'h07, 8'h00},  // R8 device number 3
        {2'd1, 4'd8,  8'h03, 8'h00},
        {2'd3, 4'd8,  8'h00, 8'h03},
        {2'd0, 4'd9,  8'h30, 8'h00},  // R9 activate
        {2'd1, 4'd9,  8'hFF, 8'h00},
        {2'd3, 4'd9,  8'h00, 8'h01},
        {2'd0, 4'd10, 8'h60, 8'h00},  // R10 base address
        {2'd1, 4'd10, 8'h12, 8'h00},
        {2'd3, 4'd10, 8'h00, 8'h12},
        {2'd0, 4'd10, 8'h61, 8'h00},
        {2'd1, 4'd10, 8'h34, 8'h00},
        {2'd3, 4'd10, 8'h00, 8'h34},
        {2'd0, 4'd8,  8'h07, 8'h00},  // R8 other bank is separate
        {2'd1, 4'd8,  8'h05, 8'h00},
        {2'd0, 4'd8,  8'h30, 8'h00},
        {2'd3, 4'd8,  8'h00, 8'h00},
        {2'd0, 4'd8,  8'h60, 8'h00},
        {2'd3, 4'd8,  8'h00, 8'h00},
        {2'd0, 4'd7,  8'h21, 8'h00},  // R7 same in bank 5
        {2'd3, 4'd7,  8'h00, 8'h3C},
        {2'd0, 4'd11, 8'h07, 8'h00},  // R11 out-of-range bank
        {2'd1, 4'd11, 8'h40, 8'h00},
        {2'd3, 4'd11, 8'h00, 8'h40},
        {2'd0, 4'd11, 8'h30, 8'h00},
        {2'd1, 4'd11, 8'h01, 8'h00},
        {2'd3, 4'd11, 8'h00, 8'h00},
        {2'd0, 4'd8,  8'h07, 8'h00},  // R10 bank 3 kept its base
        {2'd1, 4'd8,  8'h03, 8'h00},
        {2'd0, 4'd10, 8'h61, 8'h00},
        {2'd3, 4'd10, 8'h00, 8'h34},
        {2'd0, 4'd6,  8'h02, 8'h00},  // R6 wrong exit value
        {2'd1, 4'd6,  8'h01, 8'h00},
        {2'd3, 4'd6,  8'h00, 8'h00},
        {2'd2, 4'd6,  8'h00, 8'h02},
        {2'd1, 4'd6,  8'h02, 8'h00},  // R6 exit
        {2'd3, 4'd6,  8'h00, 8'hFF},
        {2'd2, 4'd6,  8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        cfg_open;
    logic [11:0] dev_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    cfgport_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata),
        .cfg_open  (cfg_open),
        .dev_active(dev_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wr    = w;
        io_rd    = r;
        io_wdata = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        io_wr = 1'b0;
        io_rd = 1'b0;
        #2;
    endtask

    task automatic unlock();
        bus(IDX, 1, 0, 8'h87);
        bus(IDX, 1, 0, 8'h01);
        bus(IDX, 1, 0, 8'h55);
        bus(IDX, 1, 0, 8'h55);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 open", {15'b0, cfg_open}, 16'h0);
        check("R1 active", {4'b0, dev_active}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] e;
            e = VEC[i];
            case (e[21:20])
                2'd0: bus(IDX, 1, 0, e[15:8]);
                2'd1: bus(DAT, 1, 0, e[15:8]);
                2'd2: begin
                    bus(IDX, 0, 1, 8'h00);
                    check($sformatf("R%0d vec %0d", e[19:16], i), {8'h0, io_rdata}, {8'h0, e[7:0]});
                end
                default: begin
                    bus(DAT, 0, 1, 8'h00);
                    check($sformatf("R%0d vec %0d", e[19:16], i), {8'h0, io_rdata}, {8'h0, e[7:0]});
                end
            endcase
        end
        idle();

        // R9 only bank 3 active, R11 did not touch bank 0
        check("R9 active vector", {4'b0, dev_active}, 16'h0008);

        // R4 closed writes leave outputs untouched
        bus(IDX, 1, 0, 8'h30);
        bus(DAT, 1, 0, 8'h00);
        idle();
        check("R4 active kept", {4'b0, dev_active}, 16'h0008);
        check("R4 still closed", {15'b0, cfg_open}, 16'h0);

        // R13 key on a foreign address
        bus(16'h002D, 1, 0, 8'h87);
        bus(16'h002D, 1, 0, 8'h01);
        bus(16'h002D, 1, 0, 8'h55);
        bus(16'h002D, 1, 0, 8'h55);
        idle();
        check("R13 no unlock", {15'b0, cfg_open}, 16'h0);
        bus(16'h0080, 0, 1, 8'h00);
        check("R13 foreign read", {8'h0, io_rdata}, 16'h0);
        idle();

        // R2 opens exactly on fourth byte
        bus(IDX, 1, 0, 8'h87);
        bus(IDX, 1, 0, 8'h01);
        bus(IDX, 1, 0, 8'h55);
        idle();
        check("R2 three bytes", {15'b0, cfg_open}, 16'h0);
        bus(IDX, 1, 0, 8'h55);
        idle();
        check("R2 four bytes", {15'b0, cfg_open}, 16'h1);

        // R12 read and write in the same cycle
        bus(IDX, 1, 0, 8'h07);
        bus(DAT, 1, 1, 8'h05);
        check("R12 old value", {8'h0, io_rdata}, 16'h0003);
        bus(DAT, 0, 1, 8'h00);
        check("R12 new value", {8'h0, io_rdata}, 16'h0005);
        idle();

        // R1 reset while open
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 reset closes", {15'b0, cfg_open}, 16'h0);
        check("R1 reset clears active", {4'b0, dev_active}, 16'h0);
        unlock();
        bus(IDX, 1, 0, 8'h07);
        bus(DAT, 0, 1, 8'h00);
        check("R1 device number", {8'h0, io_rdata}, 16'h0);
        idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule